// File: doc/BRIEF.md
# Differential Phase-Change Symbol Encoder

This block turns a serial stream of already scrambled transmit bits into phase-change symbols for a four-phase differential PSK transmitter of the 600/1200 bit/s telephone-line kind. A single clock-enable input, `tick_en`, pulses at 1200 Hz. Every second pulse closes a symbol, which gives 600 symbols per second at either data rate. The block asks the bit source for data with `bit_req`. It takes one bit per symbol in the slow mode and two bits per symbol, a dibit, in the fast mode.

Each finished symbol is turned into a phase increment of 0, 90, 180 or 270 degrees. The increment is added, modulo 360 degrees, to a running absolute carrier phase. That phase is held as a 2-bit quadrant index and goes to the carrier generator. A band-select output tells the carrier generator whether to run the low-band (calling, 1200 Hz) or the high-band (answering, 2400 Hz) carrier. The rate and band settings are latched only between symbols, so a symbol is never built under two settings.

Top module: `dpsk_symbol_encoder`

## Requirements
- R1: `sym_stb` is high, in the same cycle as `tick_en`, on every second `tick_en` pulse counted from reset (the 2nd, 4th, 6th pulse and so on), and is low in every other cycle.
- R2: `bit_req` is high on every `tick_en` pulse when `mode_active`=1 (1200 bit/s). When `mode_active`=0 (600 bit/s) it is high only on pulses that raise `sym_stb`. The value on `tx_bit` is consumed in each cycle where `bit_req` is high.
- R3: In 600 bit/s mode the bit consumed with `sym_stb` forms the symbol. A 0 advances the quadrant by 1 (+90 degrees) and a 1 advances it by 3 (+270 degrees).
- R4: In 1200 bit/s mode the first bit consumed in a symbol is the left (most significant) bit of the dibit and the second is the right bit. The dibit sets the advance: 00 gives +1 (90 degrees), 01 gives +0, 10 gives +2 (180 degrees) and 11 gives +3 (270 degrees).
- R5: `quadrant` (0..3 for 0, 90, 180 and 270 degrees) takes its new value modulo 4 in the cycle after `sym_stb`. It does not change in any other cycle.
- R6: An active-low reset sets `quadrant` to 0, `mode_active` and `band_sel` to 0, discards any half-collected dibit, and restarts the pulse count of R1.
- R7: `mode_active` loads `mode_cfg` at the clock edge of a cycle that has no `tick_en` pulse, provided no symbol is in progress (an even number of pulses seen since reset). In any other cycle a change of `mode_cfg` has no effect on `mode_active`, `bit_req` or the symbol being built.
- R8: `band_sel` (1 = high band, answering, 2400 Hz; 0 = low band, calling, 1200 Hz) loads `band_cfg` under the same symbol-boundary rule as R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | 1200 Hz single-cycle clock-enable pulse |
| tx_bit | input | 1 | Serial transmit bit, consumed when `bit_req` is high |
| mode_cfg | input | 1 | Requested rate: 0 = 600 bit/s, 1 = 1200 bit/s |
| band_cfg | input | 1 | Requested band: 0 = low/calling, 1 = high/answering |
| bit_req | output | 1 | Bit-consume strobe (1200 or 600 Hz) |
| sym_stb | output | 1 | Symbol strobe (600 Hz) |
| quadrant | output | 2 | Absolute carrier phase quadrant |
| mode_active | output | 1 | Rate in effect for the current symbol |
| band_sel | output | 1 | Band in effect, to the carrier generator |

## Verification
The phase is accumulated, so a single wrong increment or a lost first bit of a dibit offsets `quadrant` for the rest of the run. The cycle after the faulty symbol already shows a mismatch against a model that keeps the phase in degrees. A tick-phase counter that is out of step shows at once as `sym_stb` or `bit_req` on the wrong pulse. A rate or band setting latched inside a symbol shows on `mode_active`/`band_sel` one cycle later. The bench compares every output in every cycle. Its stimulus includes all four dibits, rate and band changes in the middle of a symbol, a reset in the middle of a dibit, and pulses on consecutive cycles.

// File: rtl/dpsk_enc_pkg.sv
package dpsk_enc_pkg;
  localparam int QUAD_W = 2;
  localparam int CFG_FIELDS = 2;

  typedef logic [QUAD_W-1:0] quad_t;

  typedef enum logic {
    RATE_600  = 1'b0,
    RATE_1200 = 1'b1
  } rate_e;

  // one-bit symbol: 0 -> quarter turn, 1 -> three quarter turns
  function automatic quad_t single_bit_step(input logic b);
    return b ? quad_t'(3) : quad_t'(1);
  endfunction

  // two-bit symbol, first received bit is the left bit
  function automatic quad_t dibit_step(input logic first_b, input logic second_b);
    quad_t s;
    unique case ({first_b, second_b})
      2'b00:   s = quad_t'(1);
      2'b01:   s = quad_t'(0);
      2'b10:   s = quad_t'(2);
      default: s = quad_t'(3);
    endcase
    return s;
  endfunction

  function automatic quad_t symbol_step(input rate_e r, input logic first_b,
                                        input logic last_b);
    return (r == RATE_1200) ? dibit_step(first_b, last_b) : single_bit_step(last_b);
  endfunction
endpackage

// File: rtl/dpsk_tick_seq.sv
module dpsk_tick_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic fast_rate,
  output logic sym_stb,
  output logic bit_req,
  output logic first_take,
  output logic at_boundary
);
  logic half_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       half_q <= 1'b0;
    else if (tick_en) half_q <= ~half_q;
  end

  always_comb begin
    sym_stb     = tick_en & half_q;
    first_take  = tick_en & ~half_q & fast_rate;
    bit_req     = sym_stb | first_take;
    at_boundary = ~half_q & ~tick_en;
  end
endmodule

// File: rtl/dpsk_cfg_latch.sv
module dpsk_cfg_latch #(
  parameter int FIELDS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [FIELDS-1:0] cfg_in,
  output logic [FIELDS-1:0] cfg_q
);
  for (genvar g = 0; g < FIELDS; g++) begin : g_field
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cfg_q[g] <= 1'b0;
      else if (load) cfg_q[g] <= cfg_in[g];
    end
  end
endmodule

// File: rtl/dpsk_bit_collect.sv
module dpsk_bit_collect
  import dpsk_enc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  first_take,
  input  logic  tx_bit,
  input  rate_e rate,
  output quad_t step
);
  logic first_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          first_q <= 1'b0;
    else if (first_take) first_q <= tx_bit;
  end

  always_comb step = symbol_step(rate, first_q, tx_bit);
endmodule

// File: rtl/dpsk_phase_accum.sv
module dpsk_phase_accum
  import dpsk_enc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  advance,
  input  quad_t step,
  output quad_t phase
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase <= '0;
    else if (advance) phase <= phase + step;
  end
endmodule

// File: rtl/dpsk_symbol_encoder.sv
module dpsk_symbol_encoder
  import dpsk_enc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       tx_bit,
  input  logic       mode_cfg,
  input  logic       band_cfg,
  output logic       bit_req,
  output logic       sym_stb,
  output logic [1:0] quadrant,
  output logic       mode_active,
  output logic       band_sel
);
  logic                  first_take;
  logic                  at_boundary;
  logic [CFG_FIELDS-1:0] cfg_now;
  logic [CFG_FIELDS-1:0] cfg_held;
  quad_t                 step;
  quad_t                 phase;
  rate_e                 rate;

  assign cfg_now     = {band_cfg, mode_cfg};
  assign mode_active = cfg_held[0];
  assign band_sel    = cfg_held[1];
  assign rate        = rate_e'(cfg_held[0]);
  assign quadrant    = phase;

  dpsk_tick_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .fast_rate  (cfg_held[0]),
    .sym_stb    (sym_stb),
    .bit_req    (bit_req),
    .first_take (first_take),
    .at_boundary(at_boundary)
  );

  dpsk_cfg_latch #(.FIELDS(CFG_FIELDS)) u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (at_boundary),
    .cfg_in(cfg_now),
    .cfg_q (cfg_held)
  );

  dpsk_bit_collect u_col (
    .clk       (clk),
    .rst_n     (rst_n),
    .first_take(first_take),
    .tx_bit    (tx_bit),
    .rate      (rate),
    .step      (step)
  );

  dpsk_phase_accum u_acc (
    .clk    (clk),
    .rst_n  (rst_n),
    .advance(sym_stb),
    .step   (step),
    .phase  (phase)
  );
endmodule

// File: rtl/dpsk_symbol_encoder_chk.sv
module dpsk_symbol_encoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_en,
  input logic       tx_bit,
  input logic       bit_req,
  input logic       sym_stb,
  input logic [1:0] quadrant,
  input logic       mode_active,
  input logic       band_sel
);
  logic odd_ticks;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       odd_ticks <= 1'b0;
    else if (tick_en) odd_ticks <= ~odd_ticks;
  end

  a_r1_sym_every_second_tick: assert property (@(posedge clk) disable iff (!rst_n)
    sym_stb == (tick_en && odd_ticks));

  a_r2_fast_every_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && mode_active) |-> bit_req);

  a_r2_slow_only_symbol: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_active |-> (bit_req == sym_stb));

  a_r3_single_bit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_stb && !mode_active) |=>
      (quadrant == 2'($past(quadrant) + ($past(tx_bit) ? 2'd3 : 2'd1))));

  a_r5_hold_between_symbols: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_stb |=> $stable(quadrant));

  a_r7_mode_fixed_in_symbol: assert property (@(posedge clk) disable iff (!rst_n)
    (odd_ticks || tick_en) |=> $stable(mode_active));

  a_r8_band_fixed_in_symbol: assert property (@(posedge clk) disable iff (!rst_n)
    (odd_ticks || tick_en) |=> $stable(band_sel));
endmodule

bind dpsk_symbol_encoder dpsk_symbol_encoder_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick_en    (tick_en),
  .tx_bit     (tx_bit),
  .bit_req    (bit_req),
  .sym_stb    (sym_stb),
  .quadrant   (quadrant),
  .mode_active(mode_active),
  .band_sel   (band_sel)
);

// File: tb/dpsk_symbol_encoder_test.sv
module dpsk_symbol_encoder_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       tx_bit = 1'b0;
  logic       mode_cfg = 1'b0;
  logic       band_cfg = 1'b0;
  logic       bit_req;
  logic       sym_stb;
  logic [1:0] quadrant;
  logic       mode_active;
  logic       band_sel;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference model state
  int ref_deg = 0;
  int ref_ticks = 0;
  int ref_first = 0;
  int ref_mode = 0;
  int ref_band = 0;
  string last_tag = "R6";
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  dpsk_symbol_encoder uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .tx_bit(tx_bit),
    .mode_cfg(mode_cfg), .band_cfg(band_cfg), .bit_req(bit_req),
    .sym_stb(sym_stb), .quadrant(quadrant), .mode_active(mode_active),
    .band_sel(band_sel)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int step_deg(input int fast, input int first_b, input int b);
    if (fast == 0) return (b == 1) ? 270 : 90;
    case (first_b * 2 + b)
      0: return 90;
      1: return 0;
      2: return 180;
      default: return 270;
    endcase
  endfunction

  // one clock cycle: drive at negedge, check strobes, model the edge, check state
  task automatic cycle(input logic t, input logic b);
    bit in_sym;
    tick_en = t;
    tx_bit  = b;
    #1;
    in_sym = (ref_ticks % 2) == 1;
    check("R1 sym_stb", int'(sym_stb), (t && in_sym) ? 1 : 0);
    check("R2 bit_req", int'(bit_req), (t && (in_sym || ref_mode == 1)) ? 1 : 0);
    @(posedge clk);
    if (t) begin
      if (!in_sym) begin
        if (ref_mode == 1) ref_first = int'(b);
      end else begin
        ref_deg  = (ref_deg + step_deg(ref_mode, ref_first, int'(b))) % 360;
        last_tag = (ref_mode == 1) ? "R4 quadrant" : "R3 quadrant";
      end
      ref_ticks++;
    end else if (!in_sym) begin
      ref_mode = int'(mode_cfg);
      ref_band = int'(band_cfg);
    end
    @(negedge clk);
    check(last_tag, int'(quadrant), ref_deg / 90);
    check("R5 quadrant", int'(quadrant), ref_deg / 90);
    check("R7 mode_active", int'(mode_active), ref_mode);
    check("R8 band_sel", int'(band_sel), ref_band);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick_en = 1'b0;
    ref_deg = 0; ref_ticks = 0; ref_first = 0; ref_mode = 0; ref_band = 0;
    last_tag = "R6 quadrant";
    #1;
    check("R6 quadrant", int'(quadrant), 0);
    check("R6 mode_active", int'(mode_active), 0);
    check("R6 band_sel", int'(band_sel), 0);
    check("R6 sym_stb", int'(sym_stb), 0);
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic logic next_bit();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();

    // R3: 600 bit/s, spaced ticks
    mode_cfg = 1'b0; band_cfg = 1'b0;
    cycle(0, 0);
    for (int i = 0; i < 24; i++) begin
      cycle(1, next_bit());
      cycle(0, 0);
      cycle(1, next_bit());
      cycle(0, 0);
    end

    // R4: 1200 bit/s, every dibit explicitly
    mode_cfg = 1'b1;
    cycle(0, 0);
    cycle(1, 0); cycle(1, 0);
    cycle(1, 0); cycle(1, 1);
    cycle(1, 1); cycle(1, 0);
    cycle(1, 1); cycle(1, 1);
    for (int i = 0; i < 40; i++) cycle(1, next_bit());

    // R7/R8: settings changed in mid-symbol must wait for the boundary
    cycle(0, 0);
    cycle(1, 1);
    mode_cfg = 1'b0; band_cfg = 1'b1;
    cycle(0, 0);
    cycle(0, 0);
    cycle(1, 0);
    cycle(0, 0);
    for (int i = 0; i < 10; i++) begin
      cycle(1, next_bit());
      cycle(0, 0);
    end
    mode_cfg = 1'b1; band_cfg = 1'b0;
    cycle(1, 1);
    cycle(0, 0);
    cycle(1, 0);
    cycle(0, 0);
    for (int i = 0; i < 30; i++) cycle(1, next_bit());

    // R6: reset in the middle of a dibit
    cycle(0, 0);
    cycle(1, 1);
    do_reset();
    cycle(1, 1);
    cycle(1, 0);
    mode_cfg = 1'b1;
    cycle(0, 0);
    cycle(0, 0);
    for (int i = 0; i < 60; i++) begin
      cycle((i % 3) != 2, next_bit());
      if (i == 30) band_cfg = 1'b1;
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule